// File: doc/BRIEF.md
# GPIO Interrupt Line Aggregator

This block collects the pending-interrupt status of up to five 32-bit GPIO register sets and condenses it into a row of level-sensitive parent interrupt lines for a system interrupt controller. Edge detection happens upstream. The block only sees the resulting sticky status bits, which software clears once it has serviced them.

The block has two configurations, selected by a mode pin.

**Grouped mode.** Every 16 pins share one parent line. Each register set feeds two such groups. Group `b` draws on register set `b/2`:
- an even group takes status bits 15:0 of that set;
- an odd group takes status bits 31:16.

Status bit `k` of group `b` therefore belongs to pin `(b/2)*32 + k`. Only the first `ceil(pin_count/16)` groups are live.

**Direct mode.** Each of the first `direct_count` pins of register set 0 owns a parent line of its own.

In both modes a 32-bit group-enable register, written at register offset 0x8, gates every line. The line outputs are registered, which keeps the path into the interrupt controller short.

All interfaces are plain control and status pins. Status is a level, not a stream, so there is no valid/ready handshake and no back-pressure.

Top module: `gpio_irq_aggregator`

## Requirements
- R1: In grouped mode, line `b` for an even `b` is high when any of bits 15:0 of register set `b/2` is set, provided that group is enabled and live.
- R2: In grouped mode, line `b` for an odd `b` is high when any of bits 31:16 of register set `b/2` is set, under the same conditions.
- R3: A line is a level. It stays high for as long as a contributing status bit stays set, and it falls once those bits are cleared.
- R4: Enable bit `b` gates line `b` in grouped mode. A cleared enable bit holds the line low whatever the status.
- R5: In grouped mode, only groups `b < ceil(pin_count_i/16)` can assert. Lines for higher groups, and for groups with no register set behind them (`b >= 10`), stay low.
- R6: The enable register resets to zero. It is written only when `reg_wr_i` is high and `reg_addr_i` equals 0x8. `reg_rdata_o` returns its value while `reg_addr_i` is 0x8 and returns zero at any other address. A write at any other address changes neither the register nor any line.
- R7: In direct mode, line `i` is high when status bit `i` of register set 0 is set, `i < direct_count_i`, and enable bit `i/16` is 1. Status bits of register sets 1 to 4 have no effect in this mode.
- R8: In direct mode, lines `i >= direct_count_i` stay low, so a count of zero keeps every line low.
- R9: Each line changes exactly one clock edge after the status, enable value or configuration that causes the change. A write to the enable register therefore shows on the lines at the second edge after the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| status_i | input | 160 | Pending status of the five register sets; set `s` occupies bits `32*s+31 : 32*s` |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register offset; the enable register sits at 0x8 |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data: the enable register at 0x8, zero elsewhere |
| direct_mode_i | input | 1 | 1 = direct per-pin lines, 0 = grouped lines |
| direct_count_i | input | 6 | Number of direct lines, 0 to 32 |
| pin_count_i | input | 8 | Number of GPIO pins; sets how many groups are live |
| irq_o | output | 32 | Level-sensitive parent interrupt lines |

## Verification
An enable-register write and a status change can land on the same clock edge. The line register then samples the enable value that was in place before the write, so it must not react until the following edge.

The bench provokes this by raising a status bit in the same cycle that it sets that group's enable bit. It then checks that the line is still low after the first edge and high after the second.

A second collision is a status bit clearing in the same cycle that its enable bit drops. The line must fall at the first edge and stay low afterwards.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned GROUP_W     = 16;
  localparam int unsigned GROUP_SHIFT = $clog2(GROUP_W);
  localparam int unsigned SET_W       = 32;
endpackage

// File: rtl/irq_group_slicer.sv
module irq_group_slicer
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_SETS  = 5,
  parameter int unsigned NUM_LINES = 32
) (
  input  logic [NUM_SETS*SET_W-1:0] status_i,
  output logic [NUM_LINES-1:0]      group_any_o
);
  // Group g reads register set g/2: the low half for even g, the high half for odd g.
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_group
    if ((g / 2) < NUM_SETS) begin : g_backed
      localparam int unsigned LSB = (g / 2) * SET_W + (g % 2) * GROUP_W;
      assign group_any_o[g] = |status_i[LSB +: GROUP_W];
    end else begin : g_empty
      assign group_any_o[g] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int unsigned ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] EN_OFFSET = 4'h8,
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [NUM_LINES-1:0] wdata_i,
  output logic [NUM_LINES-1:0] rdata_o,
  output logic [NUM_LINES-1:0] en_q_o
);
  logic hit;
  logic armed;

  assign hit     = (addr_i == EN_OFFSET);
  assign rdata_o = hit ? en_q_o : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           en_q_o <= '0;
    else if (wr_i && hit) en_q_o <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R6: the register only moves on a write that decodes to its offset
  assert_write_decode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !(wr_i && addr_i == EN_OFFSET)) |=> $stable(en_q_o));

  // R6: a decoded write lands exactly
  assert_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && wr_i && addr_i == EN_OFFSET) |=> (en_q_o == $past(wdata_i)));
endmodule

// File: rtl/irq_line_select.sv
module irq_line_select
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned CNT_W     = 6,
  parameter int unsigned PIN_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] group_any_i,
  input  logic [NUM_LINES-1:0] set0_i,
  input  logic [NUM_LINES-1:0] en_i,
  input  logic                 direct_mode_i,
  input  logic [CNT_W-1:0]     direct_count_i,
  input  logic [PIN_W-1:0]     pin_count_i,
  output logic [NUM_LINES-1:0] irq_o
);
  localparam int unsigned NG_W = PIN_W + 1;

  logic [NG_W-1:0]      live_groups;
  logic [NUM_LINES-1:0] grouped_hit;
  logic [NUM_LINES-1:0] direct_hit;
  logic [NUM_LINES-1:0] line_d;
  logic                 armed;

  // Number of live groups: pin count divided by the group width, rounded up.
  assign live_groups = (NG_W'(pin_count_i) + NG_W'(GROUP_W - 1)) >> GROUP_SHIFT;

  always_comb begin
    for (int i = 0; i < NUM_LINES; i++) begin
      grouped_hit[i] = group_any_i[i] & en_i[i] & (NG_W'(i) < live_groups);
      direct_hit[i]  = set0_i[i] & en_i[i / GROUP_W] & (CNT_W'(i) < direct_count_i);
    end
    line_d = direct_mode_i ? direct_hit : grouped_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= '0;
    else        irq_o <= line_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R4: with every enable bit cleared, no line can rise in grouped mode
  assert_gate_all_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !direct_mode_i && en_i == '0) |=> (irq_o == '0));

  // R5: zero pins means no live group
  assert_no_live_group_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !direct_mode_i && pin_count_i == '0) |=> (irq_o == '0));

  // R8: a direct count of zero keeps all lines low
  assert_direct_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && direct_mode_i && direct_count_i == '0) |=> (irq_o == '0));

  // R3: with no pending status in either view, every line falls
  assert_level_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && group_any_i == '0 && set0_i == '0) |=> (irq_o == '0));
endmodule

// File: rtl/gpio_irq_aggregator.sv
module gpio_irq_aggregator
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_SETS  = 5,
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned CNT_W     = 6,
  parameter int unsigned PIN_W     = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SETS*SET_W-1:0] status_i,
  input  logic                      reg_wr_i,
  input  logic [ADDR_W-1:0]         reg_addr_i,
  input  logic [NUM_LINES-1:0]      reg_wdata_i,
  output logic [NUM_LINES-1:0]      reg_rdata_o,
  input  logic                      direct_mode_i,
  input  logic [CNT_W-1:0]          direct_count_i,
  input  logic [PIN_W-1:0]          pin_count_i,
  output logic [NUM_LINES-1:0]      irq_o
);
  logic [NUM_LINES-1:0] group_any;
  logic [NUM_LINES-1:0] en_q;

  irq_group_slicer #(
    .NUM_SETS  (NUM_SETS),
    .NUM_LINES (NUM_LINES)
  ) u_slicer (
    .status_i    (status_i),
    .group_any_o (group_any)
  );

  irq_enable_reg #(
    .ADDR_W    (ADDR_W),
    .EN_OFFSET (ADDR_W'(8)),
    .NUM_LINES (NUM_LINES)
  ) u_enable (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .en_q_o  (en_q)
  );

  irq_line_select #(
    .NUM_LINES (NUM_LINES),
    .CNT_W     (CNT_W),
    .PIN_W     (PIN_W)
  ) u_select (
    .clk            (clk),
    .rst_n          (rst_n),
    .group_any_i    (group_any),
    .set0_i         (status_i[NUM_LINES-1:0]),
    .en_i           (en_q),
    .direct_mode_i  (direct_mode_i),
    .direct_count_i (direct_count_i),
    .pin_count_i    (pin_count_i),
    .irq_o          (irq_o)
  );
endmodule

// File: tb/gpio_irq_aggregator_tb.sv
`timescale 1ns/1ps
module gpio_irq_aggregator_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [159:0] status = '0;
  logic         wr = 1'b0;
  logic [3:0]   addr = 4'h8;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic         dmode = 1'b0;
  logic [5:0]   dcount = '0;
  logic [7:0]   pins = 8'd144;
  logic [31:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  gpio_irq_aggregator u_dut (
    .clk(clk), .rst_n(rst_n), .status_i(status), .reg_wr_i(wr),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .direct_mode_i(dmode), .direct_count_i(dcount), .pin_count_i(pins),
    .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  // Write the enable register; the value shows on the lines at the second edge.
  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0; addr = 4'h8;
    step();
  endtask

  task automatic t_reset();
    step();
    chk("R6 reset enable readback", rdata, 32'h0);
    status = '1; step(); step();
    chk("R4 reset lines gated", irq, 32'h0);
    status = '0; step();
  endtask

  task automatic t_even();
    dmode = 1'b0; pins = 8'd144; wr_reg(4'h8, 32'hFFFF_FFFF);
    chk("R6 readback after write", rdata, 32'hFFFF_FFFF);
    status = '0; status[3] = 1'b1; step();
    chk("R1 set0 low half -> line0", irq, 32'h0000_0001);
    status = '0; status[64+5] = 1'b1; step();
    chk("R1 set2 low half -> line4", irq, 32'h0000_0010);
    status = '0; step();
  endtask

  task automatic t_odd();
    status = '0; status[32+20] = 1'b1; step();
    chk("R2 set1 high half -> line3", irq, 32'h0000_0008);
    status = '0; status[31] = 1'b1; status[15] = 1'b1; step();
    chk("R2 set0 both halves -> lines0,1", irq, 32'h0000_0003);
    status = '0; step();
  endtask

  task automatic t_level_latency();
    @(negedge clk); status[96+2] = 1'b1;
    #1 chk("R9 no change before edge", irq, 32'h0);
    step();
    chk("R9 one edge later", irq, 32'h0000_0040);
    step(); step();
    chk("R3 stays while pending", irq, 32'h0000_0040);
    status[96+2] = 1'b0;
    #1 chk("R9 hold until edge", irq, 32'h0000_0040);
    step();
    chk("R3 falls after clear", irq, 32'h0);
  endtask

  task automatic t_enable();
    wr_reg(4'h8, 32'hFFFF_FFEF);
    status = '0; status[64] = 1'b1; status[0] = 1'b1; step();
    chk("R4 group4 disabled, group0 enabled", irq, 32'h0000_0001);
    status = '0; step();
  endtask

  task automatic t_limit();
    wr_reg(4'h8, 32'hFFFF_FFFF);
    pins = 8'd40;
    status = '0; status[32+16] = 1'b1; status[32] = 1'b1; step();
    chk("R5 40 pins: groups 0..2 live", irq, 32'h0000_0004);
    pins = 8'd144;
    status = '0; status[128+1] = 1'b1; status[128+17] = 1'b1; step();
    chk("R5 144 pins: group8 live, group9 not", irq, 32'h0000_0100);
    pins = 8'd255;
    step();
    chk("R5 255 pins: group9 live", irq, 32'h0000_0300);
    status = '0; step();
  endtask

  task automatic t_addr();
    wr_reg(4'h4, 32'h0);
    addr = 4'h8; #1;
    chk("R6 foreign write ignored", rdata, 32'hFFFF_FFFF);
    addr = 4'h4; #1;
    chk("R6 other offset reads zero", rdata, 32'h0);
    addr = 4'h8;
    status = '0; status[0] = 1'b1; step();
    chk("R6 lines still enabled", irq, 32'h0000_0001);
    status = '0; step();
  endtask

  task automatic t_direct();
    dmode = 1'b1; dcount = 6'd20; wr_reg(4'h8, 32'h0000_0003);
    status = '0; status[17] = 1'b1; status[5] = 1'b1; status[32+3] = 1'b1; step();
    chk("R7 direct lines 5,17; set1 ignored", irq, 32'h0002_0020);
    wr_reg(4'h8, 32'h0000_0001);
    chk("R7 enable bit1 gates line17", irq, 32'h0000_0020);
    wr_reg(4'h8, 32'h0000_0003);
    status = '0; status[25] = 1'b1; step();
    chk("R8 line25 beyond count 20", irq, 32'h0);
    dcount = 6'd26; step();
    chk("R8 line25 inside count 26", irq, 32'h0200_0000);
    dcount = 6'd0; status = '1; step();
    chk("R8 count zero", irq, 32'h0);
    status = '0; dmode = 1'b0; step();
  endtask

  task automatic t_collide();
    wr_reg(4'h8, 32'h0);
    @(negedge clk); wr = 1'b1; wdata = 32'h0000_0004; status[32+1] = 1'b1;
    @(negedge clk); wr = 1'b0;
    chk("R9 same-cycle write: old enable used", irq, 32'h0);
    step();
    chk("R9 same-cycle write: new enable next edge", irq, 32'h0000_0004);
    @(negedge clk); wr = 1'b1; wdata = 32'h0; status = '0;
    @(negedge clk); wr = 1'b0;
    chk("R3 clear with disable: falls", irq, 32'h0);
    step();
    chk("R4 stays low", irq, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R6 reset lines low", irq, 32'h0);
    t_reset();
    t_even();
    t_odd();
    t_level_latency();
    t_enable();
    t_limit();
    t_addr();
    t_direct();
    t_collide();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule